// File: doc/BRIEF.md
# Chainable CRC and Pseudo-Random Sequence Engine

This block computes a cyclic redundancy check or produces a pseudo-random bit sequence with a Galois-form shift register. It is made of a parameterised number of 8-bit slices. Each slice holds its own polynomial byte and its own accumulator byte. A single feedback bit is formed at the top slice and is sent to every slice. On each step every slice XORs its polynomial byte, gated by that feedback bit, into its accumulator byte and shifts the result left by one place. The bit that leaves the top of each slice enters the bottom of the slice above it. The feedback bit itself enters the bottom of slice 0, which supplies the x^0 term that is never stored.

Software first writes the polynomial and the seed one byte at a time through a small write port. It then pulses `step` once per data bit, with the data bit on `si`. The register width is chosen at run time: `msb_sel` picks the feedback tap inside the top slice, so a two-slice engine can run any width from 9 to 16 bits. A per-step enable lets CRC steps interleave with plain XOR-and-shift steps. An external mode takes the feedback bit from a port, so surrounding logic can compute it instead.

Top module: `crc_chain_engine`

## Requirements
- R1: After reset every accumulator and polynomial byte is zero, so `acc_o` reads 0.
- R2: A write with `wr_en` high stores `wr_data` into slice `wr_idx`. `wr_tgt` selects the target: 0 = polynomial, 1 = accumulator. The value is visible from the next cycle. Any write in a cycle suppresses the step of all slices in that cycle, and slices that are not written keep their value.
- R3: The tap position is bit P = 8*(SLICES-1) + `msb_sel` of the accumulator, and `msb_o` shows that bit. In internal mode, `fb_o` equals bit P XOR `si`. When `prs_mode` is 1, `si` is treated as 0.
- R4: When `step` is high and `fb_en` is 1, the accumulator becomes ((acc XOR (poly AND fb)) << 1) OR fb. The result is kept to the bits up to P. With the polynomial stored as (conventional >> 1) OR top-bit, this equals a bit-serial CRC that feeds data most-significant bit first. Example: CRC-16 CCITT is stored as 0x8810, and from a zero seed the ASCII string "123456789" yields 0x31C3.
- R5: When `step` is high and `fb_en` is 0, the polynomial is XORed in unconditionally, the accumulator shifts left, and a 0 enters bit 0.
- R6: When `ext_mode` is 1, the feedback bit is `ext_fb`. `fb_o` equals `ext_fb`, and the tap bit and `si` have no effect on the step.
- R7: After every step, the accumulator bits above position P are 0.
- R8: With neither `step` nor `wr_en` high, the accumulator holds its value.
- R9: With `prs_mode` set, an all-ones seed and a maximal-length polynomial, `msb_o` follows the 16-bit Galois sequence, whatever value `si` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_tgt | input | 1 | Write target: 0 polynomial, 1 accumulator |
| wr_idx | input | IDX_W | Slice index of the write |
| wr_data | input | 8 | Byte to write |
| msb_sel | input | 3 | Tap position inside the top slice |
| prs_mode | input | 1 | Force the serial input to 0 |
| ext_mode | input | 1 | Take the feedback bit from `ext_fb` |
| ext_fb | input | 1 | External feedback bit |
| step | input | 1 | Advance one bit |
| fb_en | input | 1 | Gate the polynomial with the feedback bit |
| si | input | 1 | Serial data bit |
| acc_o | output | 8*SLICES | Accumulator value |
| msb_o | output | 1 | Selected tap bit (sequence output) |
| fb_o | output | 1 | Current feedback bit, before gating |

## Verification
The bench runs every tap position of a two-slice engine against a bit-serial reference CRC of the matching width. Each run starts from a seed that has ones above the tap. A design that failed to clear those bits, or that took its tap from the wrong slice, would drift from the reference on the first step. The known CCITT check value tests the stored polynomial format: if the x^0 term were not shifted in, or the polynomial were not offset by one place, the result would not be 0x31C3. Three further cases each give a distinct wrong result in a faulty design:
- A step with the enable low: a design that still gated the polynomial, or shifted in the feedback bit, would give a different result.
- An external-feedback step whose port value contradicts the internal tap.
- A write that collides with a step: a design that let the step win would show a shifted byte where the written byte should be.

// File: rtl/crc_chain_pkg.sv
package crc_chain_pkg;
  localparam int unsigned SLICE_W = 8;
  localparam int unsigned POS_W   = $clog2(SLICE_W);

  typedef logic [SLICE_W-1:0] slice_t;

  // One Galois step on a single slice: gated polynomial XOR, then left shift.
  function automatic slice_t slice_next(input slice_t acc, input slice_t poly,
                                        input logic term, input logic shin);
    slice_t x;
    x = acc ^ (poly & {SLICE_W{term}});
    return {x[SLICE_W-2:0], shin};
  endfunction

  // Bit that leaves the top of a slice during a step.
  function automatic logic slice_carry(input slice_t acc, input slice_t poly,
                                       input logic term);
    return acc[SLICE_W-1] ^ (poly[SLICE_W-1] & term);
  endfunction

  // Keep bits at and below the tap, clear those above it.
  function automatic slice_t keep_upto(input logic [POS_W-1:0] sel);
    slice_t m;
    for (int i = 0; i < SLICE_W; i++) m[i] = (i <= int'(sel));
    return m;
  endfunction
endpackage

// File: rtl/crc_fb_sel.sv
module crc_fb_sel
  import crc_chain_pkg::*;
(
  input  slice_t           top_acc,
  input  logic [POS_W-1:0] msb_sel,
  input  logic             si,
  input  logic             prs_mode,
  input  logic             ext_mode,
  input  logic             ext_fb,
  input  logic             fb_en,
  output logic             msb,
  output logic             fb_raw,
  output logic             fb_term,
  output logic             fb_shift
);
  logic si_eff;

  always_comb begin
    msb      = top_acc[msb_sel];
    si_eff   = si & ~prs_mode;
    fb_raw   = ext_mode ? ext_fb : (msb ^ si_eff);
    fb_term  = fb_en ? fb_raw : 1'b1;
    fb_shift = fb_en & fb_raw;
  end
endmodule

// File: rtl/crc_slice.sv
module crc_slice
  import crc_chain_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   poly_we,
  input  logic   acc_we,
  input  slice_t wdata,
  input  logic   step,
  input  logic   fb_term,
  input  logic   shift_in,
  input  slice_t keep,
  output slice_t acc_q,
  output slice_t poly_q,
  output logic   carry_out
);
  slice_t nxt;

  always_comb begin
    nxt       = slice_next(acc_q, poly_q, fb_term, shift_in) & keep;
    carry_out = slice_carry(acc_q, poly_q, fb_term);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      poly_q <= '0;
    end else begin
      if (poly_we) poly_q <= wdata;
      if (acc_we)       acc_q <= wdata;
      else if (step)    acc_q <= nxt;
    end
  end

  // R8: an idle slice holds its accumulator
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !acc_we) |=> $stable(acc_q));

  // R2: accumulator write lands on the next cycle
  p_acc_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |=> acc_q == $past(wdata));

  // R2: polynomial changes only through its write strobe
  p_poly_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !poly_we |=> $stable(poly_q));
endmodule

// File: rtl/crc_chain_engine.sv
module crc_chain_engine
  import crc_chain_pkg::*;
#(
  parameter int unsigned SLICES  = 2,
  localparam int unsigned TOTAL_W = SLICES * SLICE_W,
  localparam int unsigned IDX_W   = (SLICES > 1) ? $clog2(SLICES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_tgt,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [SLICE_W-1:0] wr_data,
  input  logic [POS_W-1:0]   msb_sel,
  input  logic               prs_mode,
  input  logic               ext_mode,
  input  logic               ext_fb,
  input  logic               step,
  input  logic               fb_en,
  input  logic               si,
  output logic [TOTAL_W-1:0] acc_o,
  output logic               msb_o,
  output logic               fb_o
);
  slice_t              acc_s  [SLICES];
  slice_t              poly_s [SLICES];
  logic [SLICES-1:0]   carry;
  logic                step_eff;
  logic                fb_term, fb_shift;
  slice_t              top_keep;

  assign step_eff = step & ~wr_en;
  assign top_keep = keep_upto(msb_sel);

  crc_fb_sel u_fb (
    .top_acc (acc_s[SLICES-1]),
    .msb_sel (msb_sel),
    .si      (si),
    .prs_mode(prs_mode),
    .ext_mode(ext_mode),
    .ext_fb  (ext_fb),
    .fb_en   (fb_en),
    .msb     (msb_o),
    .fb_raw  (fb_o),
    .fb_term (fb_term),
    .fb_shift(fb_shift)
  );

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    logic   sel_me, sin;
    slice_t keep;
    assign sel_me = wr_en && (wr_idx == IDX_W'(i));
    if (i == 0) begin : g_bottom
      assign sin = fb_shift;
    end else begin : g_link
      assign sin = carry[i-1];
    end
    if (i == SLICES - 1) begin : g_top
      assign keep = top_keep;
    end else begin : g_low
      assign keep = '1;
    end

    crc_slice u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .poly_we  (sel_me & ~wr_tgt),
      .acc_we   (sel_me & wr_tgt),
      .wdata    (wr_data),
      .step     (step_eff),
      .fb_term  (fb_term),
      .shift_in (sin),
      .keep     (keep),
      .acc_q    (acc_s[i]),
      .poly_q   (poly_s[i]),
      .carry_out(carry[i])
    );
    assign acc_o[i*SLICE_W +: SLICE_W] = acc_s[i];
  end

  // R3: internal feedback is the tap XOR the (possibly forced) serial bit
  p_fb_internal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && fb_en && !ext_mode) |=>
      acc_o[0] == ($past(msb_o) ^ ($past(si) & ~$past(prs_mode))));

  // R5: disabled feedback shifts a zero into bit 0
  p_fb_off_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && !fb_en) |=> acc_o[0] == 1'b0);

  // R6: external feedback reaches bit 0 unchanged
  p_ext_fb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && fb_en && ext_mode) |=> acc_o[0] == $past(ext_fb));

  // R7: nothing survives above the tap after a step
  p_above_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en) |=>
      ((acc_s[SLICES-1] >> $past(msb_sel)) >> 1) == '0);
endmodule

// File: tb/sim_crc_chain_engine.sv
module sim_crc_chain_engine;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, wr_tgt = 0;
  logic [0:0]  wr_idx = 0;
  logic [7:0]  wr_data = 0;
  logic [2:0]  msb_sel = 3'd7;
  logic        prs_mode = 0, ext_mode = 0, ext_fb = 0;
  logic        step = 0, fb_en = 1, si = 0;
  logic [15:0] acc_o;
  logic        msb_o, fb_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  crc_chain_engine #(.SLICES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_idx(wr_idx),
    .wr_data(wr_data), .msb_sel(msb_sel), .prs_mode(prs_mode), .ext_mode(ext_mode),
    .ext_fb(ext_fb), .step(step), .fb_en(fb_en), .si(si),
    .acc_o(acc_o), .msb_o(msb_o), .fb_o(fb_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit tgt, input bit idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_tgt = tgt; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr16(input bit tgt, input logic [15:0] v);
    wr(tgt, 1'b0, v[7:0]);
    wr(tgt, 1'b1, v[15:8]);
  endtask

  task automatic do_step(input bit d, input bit en);
    @(negedge clk);
    step = 1; si = d; fb_en = en;
    @(negedge clk);
    step = 0;
  endtask

  // Bit-serial reference: conventional polynomial p (x^n omitted), width n.
  function automatic int ref_step(input int c, input bit d, input int p, input int n);
    int m, f;
    m = (1 << n) - 1;
    f = ((c >> (n - 1)) & 1) ^ int'(d);
    c = (c << 1) ^ (f != 0 ? p : 0);
    return c & m;
  endfunction

  function automatic logic [15:0] to_stored(input int p, input int n);
    return 16'((p >> 1) | (1 << (n - 1)));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    string msg;
    int refv;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset acc", acc_o, 0);
    si = 1; #1;
    chk("R3 fb with zero acc and si=1", fb_o, 1);
    si = 0;

    // R2: byte writes
    wr16(1'b1, 16'hA55A);
    chk("R2 acc write", acc_o, 16'hA55A);
    // R2: write beats a simultaneous step, other slice unchanged
    wr16(1'b0, 16'h8810);
    @(negedge clk);
    wr_en = 1; wr_tgt = 1; wr_idx = 1; wr_data = 8'h3C; step = 1; fb_en = 1;
    @(negedge clk);
    wr_en = 0; step = 0;
    chk("R2 write wins over step", acc_o, 16'h3C5A);

    // R8: idle cycles hold
    repeat (5) @(negedge clk);
    chk("R8 hold while idle", acc_o, 16'h3C5A);

    // R4: CCITT check string
    msg = "123456789";
    wr16(1'b1, 16'h0000);
    msb_sel = 3'd7;
    refv = 0;
    for (int k = 0; k < msg.len(); k++) begin
      for (int b = 7; b >= 0; b--) begin
        do_step(msg[k][b], 1'b1);
        refv = ref_step(refv, msg[k][b], 32'h1021, 16);
      end
      chk("R4 CCITT per byte", acc_o, refv);
    end
    chk("R4 CCITT check value", acc_o, 16'h31C3);

    // R5: disabled feedback = plain XOR and shift, zero shift-in
    wr16(1'b1, 16'h1234);
    do_step(1'b1, 1'b0);
    chk("R5 fb_en low step", acc_o, ((16'h1234 ^ 16'h8810) << 1) & 16'hFFFF);

    // R6: external feedback overrides the tap
    ext_mode = 1;
    wr16(1'b1, 16'h0000);
    ext_fb = 1; #1;
    chk("R6 fb_o follows ext_fb", fb_o, 1);
    do_step(1'b0, 1'b1);
    chk("R6 ext fb=1", acc_o, 16'h1021);
    wr16(1'b1, 16'h8001);
    ext_fb = 0;
    do_step(1'b1, 1'b1);
    chk("R6 ext fb=0 despite tap^si", acc_o, 16'h0002);
    ext_mode = 0;

    // R3/R4/R7: sweep of tap positions, seed has ones above the tap
    for (int s = 0; s < 8; s++) begin
      int n, p, c;
      n = 9 + s;
      p = ((32'hA6BD >> s) | 1) & ((1 << n) - 1);
      msb_sel = 3'(s);
      wr16(1'b0, to_stored(p, n));
      wr16(1'b1, 16'hFFFF);
      c = 32'hFFFF & ((1 << n) - 1);
      for (int k = 0; k < 24; k++) begin
        bit d;
        d = bit'(((k * 7 + s * 3) ^ (k >> 2)) & 1);
        si = d; #1;
        chk("R3 fb_o tap^si", fb_o, ((c >> (n - 1)) & 1) ^ int'(d));
        do_step(d, 1'b1);
        c = ref_step(c, d, p, n);
        chk("R4 sweep step", acc_o, c);
        chk("R7 above tap clear", int'(acc_o >> n), 0);
      end
    end

    // R9: PRS with si ignored
    msb_sel = 3'd7;
    prs_mode = 1;
    wr16(1'b0, to_stored(32'h002D, 16));
    wr16(1'b1, 16'hFFFF);
    refv = 16'hFFFF;
    for (int k = 0; k < 300; k++) begin
      chk("R9 PRS msb_o", msb_o, (refv >> 15) & 1);
      do_step(1'b1, 1'b1);
      refv = ref_step(refv, 1'b0, 32'h002D, 16);
    end
    chk("R9 PRS state", acc_o, refv);
    prs_mode = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule